// File: doc/BRIEF.md
# Supply Supervisor Alarm Timer

This block is the digital part of a supply-voltage supervisor in a smart-card interface. Two analog comparators feed it. One reports that the supply is above the upper threshold, which is the switch-off level plus hysteresis. The other reports that the supply has dropped below the lower threshold. The block tracks whether the supply is good. From that state it drives an alarm of both polarities toward the host controller, and it tells the contact sequencer when it may run.

When the supply rises past the upper threshold, a delay starts. The alarm stays asserted until that delay has run out. When the supply drops below the lower threshold, the alarm asserts at once and a single-cycle request is sent to the contact deactivation sequencer. Every crossing, rising or falling, reloads the full alarm width. This makes the pulse retriggerable, with a guaranteed minimum length. A free-running tick input is the time base, so the width is given as a number of ticks. The comparator inputs are first passed through a two-flop synchronizer. The asynchronous reset acts as the power-on reset.

Top module: `supply_alarm_timer`

## Requirements
- R1: While reset is asserted and right after it, `alarm_o`=1, `alarm_n_o`=0, `deact_req_o`=0 and `seq_enable_o`=0.
- R2: `alarm_n_o` is always the inverse of `alarm_o`.
- R3: When `sup_above_hi` rises while the supply is not good (and `sup_below_lo` is 0), the crossing is registered at the third rising clock edge. The alarm then stays 1 and is released at the edge that consumes the ALARM_TICKS-th tick counted after that edge.
- R4: When `sup_below_lo` rises while the supply is good, `alarm_o` goes to 1 at the third rising clock edge after the input change and not before.
- R5: Each falling crossing gives exactly one `deact_req_o` pulse of one clock cycle, in the same cycle the alarm asserts. Holding `sup_below_lo` high gives no further pulse.
- R6: A crossing in either direction while the alarm is counting restarts the full ALARM_TICKS count.
- R7: After a falling crossing, the supply counts as not good until `sup_above_hi` is seen again. Ticks in the meantime never release the alarm.
- R8: When both comparator inputs are 1, the below-threshold input wins: the supply counts as not good.
- R9: `seq_enable_o` is 1 only when the supply is good and the alarm is released, that is, exactly when `alarm_o` is 0.
- R10: A tick in the same cycle as a crossing is not counted. A tick while the count is already zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| tick | input | 1 | Time-base strobe; one count per cycle it is high |
| sup_above_hi | input | 1 | Comparator: supply above upper threshold (asynchronous) |
| sup_below_lo | input | 1 | Comparator: supply below lower threshold (asynchronous) |
| alarm_o | output | 1 | Alarm, active high |
| alarm_n_o | output | 1 | Alarm, active low |
| deact_req_o | output | 1 | One-cycle request to start contact deactivation |
| seq_enable_o | output | 1 | Contact sequencer may be enabled |

## Verification
The bench builds the block with ALARM_TICKS set to 5. With that value, every tick position inside the alarm window can be reached in a short run. The bench sweeps four gap lengths between ticks during power-up. It places a retriggering glitch after each possible number of consumed ticks, from 0 to 4. It also holds the tick high without a break to probe the edge where a crossing coincides with a tick. Each expected release edge is the load edge plus the ALARM_TICKS-th tick, counted by the bench.

// File: rtl/sat_pkg.sv
package sat_pkg;
    // Crossing events produced by the threshold tracker.
    typedef struct packed {
        logic rise;   // supply became good (upper threshold seen)
        logic fall;   // supply became bad (lower threshold seen)
    } sat_evt_t;
endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } stage_t;

    for (genvar b = 0; b < N; b++) begin : g_bit
        stage_t st_d, st_q;

        always_comb begin
            st_d.s1 = d_i[b];
            st_d.s2 = st_q.s1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign q_o[b] = st_q.s2;
    end
endmodule

// File: rtl/sat_level.sv
module sat_level
    import sat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hi_i,
    input  logic     lo_i,
    output logic     good_d_o,
    output sat_evt_t evt_o
);
    typedef struct packed {
        logic good;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        evt_o = '0;
        if (lo_i) begin
            // lower threshold dominates (R8)
            st_d.good  = 1'b0;
            evt_o.fall = st_q.good;
        end else if (hi_i) begin
            st_d.good  = 1'b1;
            evt_o.rise = !st_q.good;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign good_d_o = st_d.good;

    assert_lo_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lo_i |=> !st_q.good);

    assert_hi_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_i && !lo_i) |=> st_q.good);

    assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_i && !lo_i) |=> $stable(st_q.good));
endmodule

// File: rtl/sat_timer.sv
module sat_timer #(
    parameter int TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    output logic busy_d_o
);
    localparam int CNT_W = (TICKS < 2) ? 1 : $clog2(TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = CNT_W'(TICKS);
        end else if (tick_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_d_o = (st_d.cnt != '0);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.cnt != '0) |=>
            (st_q.cnt == $past(st_q.cnt) || st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    assert_idle_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.cnt == '0) |=> (st_q.cnt == '0));

    assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(TICKS));
endmodule

// File: rtl/supply_alarm_timer.sv
module supply_alarm_timer
    import sat_pkg::*;
#(
    parameter int ALARM_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sup_above_hi,
    input  logic sup_below_lo,
    output logic alarm_o,
    output logic alarm_n_o,
    output logic deact_req_o,
    output logic seq_enable_o
);
    localparam int N_CMP = 2;

    typedef struct packed {
        logic alarm_hi;
        logic alarm_lo_n;
        logic deact;
        logic seq_en;
    } out_t;

    logic [N_CMP-1:0] cmp_s;
    logic             good_d;
    logic             busy_d;
    sat_evt_t         evt;
    out_t             out_d, out_q;

    sat_sync #(.N(N_CMP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sup_below_lo, sup_above_hi}),
        .q_o   (cmp_s)
    );

    sat_level u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_i     (cmp_s[0]),
        .lo_i     (cmp_s[1]),
        .good_d_o (good_d),
        .evt_o    (evt)
    );

    sat_timer #(.TICKS(ALARM_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (evt.rise | evt.fall),
        .tick_i   (tick),
        .busy_d_o (busy_d)
    );

    always_comb begin
        out_d.alarm_hi   = !good_d || busy_d;
        out_d.alarm_lo_n = good_d && !busy_d;
        out_d.deact      = evt.fall;
        out_d.seq_en     = good_d && !busy_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{alarm_hi: 1'b1, alarm_lo_n: 1'b0, deact: 1'b0, seq_en: 1'b0};
        else        out_q <= out_d;
    end

    assign alarm_o      = out_q.alarm_hi;
    assign alarm_n_o    = out_q.alarm_lo_n;
    assign deact_req_o  = out_q.deact;
    assign seq_enable_o = out_q.seq_en;

    assert_polarity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o != alarm_n_o);

    assert_fall_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt.fall |=> (alarm_o && deact_req_o));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        deact_req_o |=> !deact_req_o);

    assert_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.rise || evt.fall) |=> alarm_o);

    assert_seq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_enable_o |-> !alarm_o);
endmodule

// File: tb/supply_alarm_timer_tb.sv
`timescale 1ns/1ps
module supply_alarm_timer_tb;
    localparam int W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic hi = 1'b0;
    logic lo = 1'b0;
    logic alarm, alarm_n, deact, seq_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    supply_alarm_timer #(.ALARM_TICKS(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .sup_above_hi (hi),
        .sup_below_lo (lo),
        .alarm_o      (alarm),
        .alarm_n_o    (alarm_n),
        .deact_req_o  (deact),
        .seq_enable_o (seq_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // alarm outputs as a group; expected alarm level a
    task automatic chk_alarm(input string tag, input logic a);
        chk({tag, " alarm"}, alarm, a);
        chk({"R2 ", tag, " alarm_n"}, alarm_n, !a);
        chk({"R9 ", tag, " seq_en"}, seq_en, !a);
    endtask

    // rise from not-good; ticks separated by gap idle cycles
    task automatic power_up(input int gap);
        hi = 1'b1;
        cyc(3);                         // load edge passed
        for (int i = 0; i < W; i++) begin
            chk_alarm("R3 before tick", 1'b1);
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
            cyc(gap);
        end
        chk_alarm("R3 released", 1'b0);
    endtask

    // fall from good, hold low, then sit between thresholds
    task automatic power_down();
        hi = 1'b0;
        lo = 1'b1;
        cyc(2);
        chk_alarm("R4 not early", 1'b0);
        chk("R5 no early pulse", deact, 1'b0);
        cyc(1);
        chk_alarm("R4 asserted", 1'b1);
        chk("R5 pulse", deact, 1'b1);
        for (int i = 0; i < 6; i++) begin
            cyc(1);
            chk("R5 single pulse", deact, 1'b0);
        end
        lo = 1'b0;
        cyc(3);
        for (int i = 0; i < 2 * W; i++) begin
            tick = 1'b1;
            cyc(1);
        end
        tick = 1'b0;
        cyc(1);
        chk_alarm("R7 between thresholds", 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        chk_alarm("R1 in reset", 1'b1);
        chk("R1 deact", deact, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        chk_alarm("R1 after reset", 1'b1);
        chk("R1 deact after", deact, 1'b0);

        // R10: ticks with nothing loaded do nothing; R7: still not good
        for (int i = 0; i < 8; i++) begin
            tick = 1'b1;
            cyc(1);
        end
        tick = 1'b0;
        cyc(1);
        chk_alarm("R10 idle ticks", 1'b1);

        // R3 sweep over tick spacing
        for (int g = 0; g < 4; g++) begin
            power_up(g);
            power_down();
        end

        // R6 retrigger after k consumed ticks
        for (int k = 0; k < W; k++) begin
            hi = 1'b1;
            cyc(3);
            for (int i = 0; i < k; i++) begin
                tick = 1'b1;
                cyc(1);
            end
            tick = 1'b0;
            lo = 1'b1;
            cyc(1);
            lo = 1'b0;
            cyc(2);
            chk("R5 glitch pulse", deact, 1'b1);
            chk_alarm("R6 glitch", 1'b1);
            cyc(1);
            chk("R5 glitch pulse ends", deact, 1'b0);
            for (int i = 0; i < W - 1; i++) begin
                tick = 1'b1;
                cyc(1);
            end
            tick = 1'b0;
            chk_alarm("R6 full count restarted", 1'b1);
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
            chk_alarm("R6 release", 1'b0);
            power_down();
        end

        // R8 both inputs high
        power_up(1);
        lo = 1'b1;
        cyc(3);
        chk("R8 pulse", deact, 1'b1);
        for (int i = 0; i < 2 * W; i++) begin
            tick = 1'b1;
            cyc(1);
        end
        tick = 1'b0;
        chk_alarm("R8 lo wins", 1'b1);
        lo = 1'b0;
        cyc(3);
        for (int i = 0; i < W; i++) begin
            tick = 1'b1;
            cyc(1);
        end
        tick = 1'b0;
        chk_alarm("R8 recovered", 1'b0);
        power_down();

        // R10 tick held high across the load edge
        tick = 1'b1;
        hi = 1'b1;
        cyc(3);
        chk_alarm("R10 load edge", 1'b1);
        cyc(W - 1);
        chk_alarm("R10 coincident tick not counted", 1'b1);
        cyc(1);
        chk_alarm("R10 release", 1'b0);
        tick = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule